// File: doc/BRIEF.md
# Protection-Violation Interrupt Status Unit

This block collects fault reports from a memory protection checker and turns them into one interrupt line. The checker sends single-cycle pulses for six kinds of fault: aperture parity error, TrustZone violation, aperture permission violation, ID parity error, write to a read-only ID entry and ID miss. The block records the first of these, together with the address, master ID and direction of the offending transaction. It then ignores later checker faults until software clears the recorded ones.

Software reaches the block over an APB slave port. The port exposes a control word, the status word, a mask word and two read-only capture words. Two kinds of bad access on this port are flagged in a separate status bit and answered with a slave error: an access to an offset that does not exist, and any non-secure transfer. That bit is not subject to the lockout.

Top module: `prot_irq_status`

## Requirements
- R1: After reset, status reads 0x0, control reads 0x0, both capture words read 0x0, mask reads 0xEF, and irq is 0.
- R2: The status word at offset 0x10 has these bit positions: 7 aperture parity, 6 TrustZone, 5 permission, 3 ID parity, 2 read-only write, 1 ID miss, 0 bad APB access. Bits 31:8 and bit 4 read as 0.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it as it was.
- R4: irq is 1 exactly when some status bit is 1 and the mask bit at the same position is 0.
- R5: While any status bit 7..1 is set, checker pulses change no status bit.
- R6: Control word at offset 0x00: bit 0 is the global enable, bit 1 the ID parity enable and bit 2 the aperture parity enable. A read-only pulse counts only when bit 0 is 1. An ID parity pulse counts only when bit 1 is 1. An aperture parity pulse counts only when bit 2 is 1. The other pulses always count.
- R7: An access to an offset other than 0x00, 0x10, 0x14, 0x18 or 0x1C, including an unaligned one, returns pslverr=1 and prdata=0. It sets status bit 0 and changes no register.
- R8: A transfer with p_nonsec=1 returns pslverr=1 and prdata=0 at any offset. It sets status bit 0 and changes no register.
- R9: When a checker fault is recorded, the read-only capture words take the transaction details. Offset 0x18 holds the address. Offset 0x1C holds the master ID in its low bits and the write flag in bit 31. Both words keep their values while status bits 7..1 are not all clear.
- R10: Pulses that arrive together while unlocked all set their status bits in the same cycle, and one capture records that transaction.
- R11: When a status clear and a counted new fault fall in the same cycle, the fault's bit ends up set.
- R12: The mask word at offset 0x14 follows the status layout. Writing 1 masks a bit and writing 0 unmasks it. Bits 31:8 and bit 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| p_nonsec | input | 1 | Transfer is non-secure when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Slave error for a rejected access |
| vio_aper_par | input | 1 | Aperture parity error pulse |
| vio_tz | input | 1 | TrustZone violation pulse |
| vio_perm | input | 1 | Aperture permission violation pulse |
| vio_id_par | input | 1 | ID parity error pulse |
| vio_ro_wr | input | 1 | Write to read-only ID pulse |
| vio_id_miss | input | 1 | ID not found pulse |
| vio_addr | input | VA_W | Address of the faulting transaction |
| vio_id | input | ID_W | Master ID of the faulting transaction |
| vio_is_write | input | 1 | Faulting transaction was a write |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume an APB master that holds psel through both phases and raises penable only in the second. They also assume checker pulses and their detail inputs are sampled on the edge where the pulses are high. The bench drives every input on the falling edge and holds each pulse for one cycle. It builds transfers only as a setup cycle followed by an access cycle. Random steps mix faults, clears, bad offsets and non-secure transfers, so the lockout is entered and left many times within those rules.

// File: rtl/prot_irq_pkg.sv
package prot_irq_pkg;
  localparam int DW = 32;
  localparam int SW = 8;

  // status bit positions
  localparam int BIT_APB   = 0;
  localparam int BIT_MISS  = 1;
  localparam int BIT_RO    = 2;
  localparam int BIT_IDPAR = 3;
  localparam int BIT_PERM  = 5;
  localparam int BIT_TZ    = 6;
  localparam int BIT_APAR  = 7;
  localparam logic [SW-1:0] STAT_IMPL = 8'hEF;
  localparam logic [SW-1:0] LOCK_GRP  = 8'hEE;

  // control bit positions
  localparam int CW        = 3;
  localparam int CTL_EN    = 0;
  localparam int CTL_IDPAR = 1;
  localparam int CTL_APAR  = 2;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_STAT, SEL_MASK, SEL_CAPA, SEL_CAPI, SEL_NONE
  } reg_sel_e;

  localparam int NREG = 5;
  localparam logic [7:0] OFS_TAB [NREG] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C};
endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/prot_apb_dec.sv
module prot_apb_dec
  import prot_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              p_nonsec,
  input  logic [ADDR_W-1:0] paddr,
  output logic              acc_ok,
  output logic              wr_ok,
  output logic              err,
  output reg_sel_e          sel
);
  logic access;
  logic hit;

  assign access = psel & penable;

  always_comb begin
    sel = SEL_NONE;
    hit = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (paddr == ADDR_W'(OFS_TAB[i])) begin
        sel = reg_sel_e'(i);
        hit = 1'b1;
      end
    end
  end

  assign err    = access & (p_nonsec | ~hit);
  assign acc_ok = access & ~err;
  assign wr_ok  = acc_ok & pwrite;
endmodule

// File: rtl/prot_regbank.sv
module prot_regbank
  import prot_irq_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_ns,
  input  logic            acc_ok,
  input  logic            wr_ok,
  input  reg_sel_e        sel,
  input  logic [DW-1:0]   pwdata,
  input  logic [SW-1:0]   status_q,
  input  logic [VA_W-1:0] cap_addr_q,
  input  logic [ID_W-1:0] cap_id_q,
  input  logic            cap_wr_q,
  output logic [CW-1:0]   ctrl_q,
  output logic [SW-1:0]   mask_q,
  output logic [DW-1:0]   rdata
);
  logic [CW-1:0] ctrl_d;
  logic [SW-1:0] mask_d;
  logic          ctrl_en, mask_en;
  logic [DW-1:0] mux;
  logic          unused_wdata_hi;

  assign unused_wdata_hi = ^pwdata[DW-1:SW];

  assign ctrl_en = wr_ok & (sel == SEL_CTRL);
  assign mask_en = wr_ok & (sel == SEL_MASK);

  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    if (ctrl_en) ctrl_d = pwdata[CW-1:0];
    if (mask_en) mask_d = pwdata[SW-1:0] & STAT_IMPL;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q <= '0;
      mask_q <= STAT_IMPL;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    mux = '0;
    unique case (sel)
      SEL_CTRL: mux = DW'(ctrl_q);
      SEL_STAT: mux = DW'(status_q);
      SEL_MASK: mux = DW'(mask_q);
      SEL_CAPA: mux = DW'(cap_addr_q);
      SEL_CAPI: begin
        mux = DW'(cap_id_q);
        mux[DW-1] = cap_wr_q;
      end
      default:  mux = '0;
    endcase
  end

  assign rdata = acc_ok ? mux : '0;
endmodule

// File: rtl/prot_vio_latch.sv
module prot_vio_latch
  import prot_irq_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_ns,
  input  logic [SW-1:0]   vio_vec,
  input  logic [CW-1:0]   ctrl_q,
  input  logic [SW-1:0]   clr_vec,
  input  logic            apb_err,
  input  logic [VA_W-1:0] vio_addr,
  input  logic [ID_W-1:0] vio_id,
  input  logic            vio_is_write,
  output logic [SW-1:0]   status_q,
  output logic [VA_W-1:0] cap_addr_q,
  output logic [ID_W-1:0] cap_id_q,
  output logic            cap_wr_q
);
  logic [SW-1:0]   gate;
  logic [SW-1:0]   counted;
  logic [SW-1:0]   set_vec;
  logic [SW-1:0]   status_d;
  logic            locked;
  logic            cap_en;
  logic [VA_W-1:0] cap_addr_d;
  logic [ID_W-1:0] cap_id_d;
  logic            cap_wr_d;

  always_comb begin
    gate             = LOCK_GRP;
    gate[BIT_RO]     = ctrl_q[CTL_EN];
    gate[BIT_IDPAR]  = ctrl_q[CTL_IDPAR];
    gate[BIT_APAR]   = ctrl_q[CTL_APAR];
  end

  assign counted = vio_vec & gate;
  assign locked  = |(status_q & LOCK_GRP);
  assign cap_en  = ~locked & (|counted);

  always_comb begin
    set_vec          = cap_en ? counted : '0;
    set_vec[BIT_APB] = apb_err;
    // new events win over a same-cycle clear
    status_d = ((status_q & ~clr_vec) | set_vec) & STAT_IMPL;
  end

  always_comb begin
    cap_addr_d = cap_addr_q;
    cap_id_d   = cap_id_q;
    cap_wr_d   = cap_wr_q;
    if (cap_en) begin
      cap_addr_d = vio_addr;
      cap_id_d   = vio_id;
      cap_wr_d   = vio_is_write;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      status_q   <= '0;
      cap_addr_q <= '0;
      cap_id_q   <= '0;
      cap_wr_q   <= 1'b0;
    end else begin
      status_q   <= status_d;
      cap_addr_q <= cap_addr_d;
      cap_id_q   <= cap_id_d;
      cap_wr_q   <= cap_wr_d;
    end
  end
endmodule

// File: rtl/prot_irq_status.sv
module prot_irq_status
  import prot_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VA_W   = 32,
  parameter int ID_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              p_nonsec,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              vio_aper_par,
  input  logic              vio_tz,
  input  logic              vio_perm,
  input  logic              vio_id_par,
  input  logic              vio_ro_wr,
  input  logic              vio_id_miss,
  input  logic [VA_W-1:0]   vio_addr,
  input  logic [ID_W-1:0]   vio_id,
  input  logic              vio_is_write,
  output logic              irq
);
  logic            rst_ns;
  logic            acc_ok, wr_ok, apb_err;
  reg_sel_e        sel;
  logic [CW-1:0]   ctrl_q;
  logic [SW-1:0]   mask_q;
  logic [SW-1:0]   status_q;
  logic [SW-1:0]   vio_vec;
  logic [SW-1:0]   clr_vec;
  logic [VA_W-1:0] cap_addr_q;
  logic [ID_W-1:0] cap_id_q;
  logic            cap_wr_q;

  prot_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  prot_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .p_nonsec(p_nonsec),
    .paddr(paddr), .acc_ok(acc_ok), .wr_ok(wr_ok), .err(apb_err), .sel(sel)
  );

  always_comb begin
    vio_vec            = '0;
    vio_vec[BIT_APAR]  = vio_aper_par;
    vio_vec[BIT_TZ]    = vio_tz;
    vio_vec[BIT_PERM]  = vio_perm;
    vio_vec[BIT_IDPAR] = vio_id_par;
    vio_vec[BIT_RO]    = vio_ro_wr;
    vio_vec[BIT_MISS]  = vio_id_miss;
  end

  assign clr_vec = (wr_ok && sel == SEL_STAT) ? (pwdata[SW-1:0] & STAT_IMPL) : '0;

  prot_vio_latch #(.VA_W(VA_W), .ID_W(ID_W)) u_lat (
    .clk(clk), .rst_ns(rst_ns), .vio_vec(vio_vec), .ctrl_q(ctrl_q),
    .clr_vec(clr_vec), .apb_err(apb_err), .vio_addr(vio_addr),
    .vio_id(vio_id), .vio_is_write(vio_is_write), .status_q(status_q),
    .cap_addr_q(cap_addr_q), .cap_id_q(cap_id_q), .cap_wr_q(cap_wr_q)
  );

  prot_regbank #(.VA_W(VA_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_ns(rst_ns), .acc_ok(acc_ok), .wr_ok(wr_ok), .sel(sel),
    .pwdata(pwdata), .status_q(status_q), .cap_addr_q(cap_addr_q),
    .cap_id_q(cap_id_q), .cap_wr_q(cap_wr_q), .ctrl_q(ctrl_q),
    .mask_q(mask_q), .rdata(prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = apb_err;
  assign irq     = |(status_q & ~mask_q);
endmodule

// File: rtl/prot_irq_status_chk.sv
module prot_irq_status_chk #(
  parameter int ADDR_W = 8,
  parameter int VA_W   = 32
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic              p_nonsec,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       prdata,
  input logic              pslverr,
  input logic              irq,
  input logic [7:0]        status_q,
  input logic [2:0]        ctrl_q,
  input logic [VA_W-1:0]   cap_addr_q
);
  logic acc, stat_wr, locked;
  assign acc     = psel & penable;
  assign stat_wr = acc & pwrite & ~p_nonsec & (paddr == ADDR_W'(8'h10));
  assign locked  = |status_q[7:1];

  // R7
  slverr_in_access_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pslverr |-> acc);

  // R8
  slverr_sets_bit0_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pslverr |=> status_q[0]);

  // R2
  stat_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (acc && !p_nonsec && paddr == ADDR_W'(8'h10)) |-> (prdata[31:8] == 24'h0 && !prdata[4]));

  // R5
  lock_holds_group_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (locked && !stat_wr) |=> (status_q[7:1] == $past(status_q[7:1])));

  // R9
  capture_held_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    locked |=> $stable(cap_addr_q));

  // R6
  ro_gated_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl_q[0] && !status_q[2]) |=> !status_q[2]);

  // R4
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq |-> (|status_q));
endmodule

bind prot_irq_status prot_irq_status_chk #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .psel(psel), .penable(penable), .pwrite(pwrite),
  .p_nonsec(p_nonsec), .paddr(paddr), .prdata(prdata), .pslverr(pslverr),
  .irq(irq), .status_q(status_q), .ctrl_q(ctrl_q), .cap_addr_q(cap_addr_q)
);

// File: tb/sim_prot_irq_status.sv
`timescale 1ns/1ps
module sim_prot_irq_status;
  localparam int ADDR_W = 8;
  localparam int VA_W   = 32;
  localparam int ID_W   = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic psel, penable, pwrite, p_nonsec;
  logic [ADDR_W-1:0] paddr;
  logic [31:0] pwdata, prdata;
  logic pready, pslverr;
  logic vio_aper_par, vio_tz, vio_perm, vio_id_par, vio_ro_wr, vio_id_miss;
  logic [VA_W-1:0] vio_addr;
  logic [ID_W-1:0] vio_id;
  logic vio_is_write;
  logic irq;

  always #5 clk = ~clk;

  prot_irq_status #(.ADDR_W(ADDR_W), .VA_W(VA_W), .ID_W(ID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .p_nonsec(p_nonsec), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .vio_aper_par(vio_aper_par),
    .vio_tz(vio_tz), .vio_perm(vio_perm), .vio_id_par(vio_id_par),
    .vio_ro_wr(vio_ro_wr), .vio_id_miss(vio_id_miss), .vio_addr(vio_addr),
    .vio_id(vio_id), .vio_is_write(vio_is_write), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [7:0]      m_stat, m_mask;
  logic [2:0]      m_ctrl;
  logic [VA_W-1:0] m_capa;
  logic [ID_W-1:0] m_capi;
  logic            m_capw;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit ofs_ok(input logic [7:0] a);
    return a == 8'h00 || a == 8'h10 || a == 8'h14 || a == 8'h18 || a == 8'h1C;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return {29'h0, m_ctrl};
      8'h10: return {24'h0, m_stat};
      8'h14: return {24'h0, m_mask};
      8'h18: return m_capa;
      8'h1C: return {m_capw, 21'h0, m_capi};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void mstep(input bit acc, input logic [7:0] a, input logic [31:0] wd,
                                input bit wr, input bit ns, input logic [7:0] pv,
                                input logic [VA_W-1:0] va, input logic [ID_W-1:0] vid,
                                input bit vw);
    logic [7:0] g, nst;
    bit lock, err;
    lock = |m_stat[7:1];
    g    = pv & {m_ctrl[2], 1'b1, 1'b1, 1'b0, m_ctrl[1], m_ctrl[0], 1'b1, 1'b0};
    err  = acc && (ns || !ofs_ok(a));
    nst  = m_stat;
    if (acc && !err && wr) begin
      case (a)
        8'h00: m_ctrl = wd[2:0];
        8'h10: nst = nst & ~(wd[7:0] & 8'hEF);
        8'h14: m_mask = wd[7:0] & 8'hEF;
        default: ;
      endcase
    end
    if (err) nst[0] = 1'b1;
    if (!lock && |g) begin
      nst = nst | g;
      m_capa = va; m_capi = vid; m_capw = vw;
    end
    m_stat = nst;
  endfunction

  task automatic drive_pv(input logic [7:0] pv);
    vio_aper_par = pv[7]; vio_tz = pv[6]; vio_perm = pv[5];
    vio_id_par = pv[3]; vio_ro_wr = pv[2]; vio_id_miss = pv[1];
  endtask

  task automatic chk_irq(input string tag);
    #1 chk({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_stat & ~m_mask)});
  endtask

  // APB transfer, optional checker pulses during the access cycle
  task automatic xfer(input string tag, input logic [7:0] a, input logic [31:0] wd,
                      input bit wr, input bit ns, input logic [7:0] pv);
    logic [31:0] erd;
    bit eerr;
    logic [VA_W-1:0] va;
    logic [ID_W-1:0] vid;
    bit vw;
    va = $urandom; vid = ID_W'($urandom); vw = $urandom % 2;
    eerr = ns || !ofs_ok(a);
    erd  = (eerr || wr) ? 32'h0 : mread(a);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; p_nonsec = ns; paddr = a; pwdata = wd;
    @(negedge clk);
    penable = 1; drive_pv(pv); vio_addr = va; vio_id = vid; vio_is_write = vw;
    #1;
    chk({tag, " pslverr"}, {31'h0, pslverr}, {31'h0, eerr});
    if (!wr) chk({tag, " prdata"}, prdata, erd);
    mstep(1'b1, a, wd, wr, ns, pv, va, vid, vw);
    @(negedge clk);
    psel = 0; penable = 0; drive_pv(8'h0);
    chk_irq(tag);
  endtask

  task automatic pulse(input string tag, input logic [7:0] pv,
                       input logic [VA_W-1:0] va, input logic [ID_W-1:0] vid, input bit vw);
    @(negedge clk);
    drive_pv(pv); vio_addr = va; vio_id = vid; vio_is_write = vw;
    mstep(1'b0, 8'h0, 32'h0, 1'b0, 1'b0, pv, va, vid, vw);
    @(negedge clk);
    drive_pv(8'h0);
    chk_irq(tag);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    xfer(tag, a, 32'h0, 1'b0, 1'b0, 8'h0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; p_nonsec = 0; paddr = '0;
    pwdata = '0; drive_pv(8'h0); vio_addr = '0; vio_id = '0; vio_is_write = 0;
    m_stat = 0; m_mask = 8'hEF; m_ctrl = 0; m_capa = 0; m_capi = 0; m_capw = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd("R1 ctrl", 8'h00); rd("R1 status", 8'h10); rd("R1 mask", 8'h14);
    rd("R1 capa", 8'h18); rd("R1 capi", 8'h1C);

    // R12 mask semantics and reserved bits
    xfer("R12 mask wr0", 8'h14, 32'h0, 1, 0, 0); rd("R12 mask rd0", 8'h14);
    xfer("R12 mask wr1", 8'h14, 32'hFFFF_FFFF, 1, 0, 0); rd("R12 mask rd1", 8'h14);

    // R6 gating with enables off
    pulse("R6 gated off", 8'h8C, 32'hA0A0_0001, 10'h011, 1);
    rd("R6 status gated", 8'h10);
    xfer("R6 ctrl on", 8'h00, 32'h7, 1, 0, 0); rd("R6 ctrl rd", 8'h00);
    pulse("R6 ro counted", 8'h04, 32'h1234_5678, 10'h2A5, 1);
    rd("R6 status ro", 8'h10);
    rd("R9 capa first", 8'h18); rd("R9 capi first", 8'h1C);

    // R5 lockout and R9 capture held
    pulse("R5 locked tz", 8'h40, 32'hDEAD_BEEF, 10'h3FF, 0);
    rd("R5 status locked", 8'h10); rd("R9 capa held", 8'h18); rd("R9 capi held", 8'h1C);

    // R3 write-0 no effect, write-1 clears
    xfer("R3 write0", 8'h10, 32'h0, 1, 0, 0); rd("R3 after w0", 8'h10);
    xfer("R3 write1", 8'h10, 32'h04, 1, 0, 0); rd("R3 after w1", 8'h10);

    // R10 simultaneous pulses
    pulse("R10 multi", 8'h62, 32'h0BAD_F00D, 10'h155, 0);
    rd("R10 status", 8'h10); rd("R10 capa", 8'h18); rd("R10 capi", 8'h1C);
    xfer("R3 clr all", 8'h10, 32'hFF, 1, 0, 0); rd("R3 cleared", 8'h10);

    // R11 same-cycle clear and new fault
    xfer("R11 clr+miss", 8'h10, 32'hFF, 1, 0, 8'h02); rd("R11 status", 8'h10);
    xfer("R11 clr", 8'h10, 32'hFF, 1, 0, 0);

    // R7 bad offsets, R8 non-secure
    rd("R7 unimpl rd", 8'h04); rd("R7 status bit0", 8'h10);
    xfer("R7 unaligned wr", 8'h15, 32'h0, 1, 0, 0); rd("R7 mask unchanged", 8'h14);
    xfer("R8 ns ctrl wr", 8'h00, 32'h0, 1, 1, 0); rd("R8 ctrl unchanged", 8'h00);
    xfer("R8 ns rd", 8'h10, 32'h0, 0, 1, 0);
    rd("R2 status layout", 8'h10);

    // R4 irq vs mask
    xfer("R4 unmask bit0", 8'h14, 32'hEE, 1, 0, 0);
    xfer("R4 mask bit0", 8'h14, 32'hEF, 1, 0, 0);
    xfer("R4 clr bit0", 8'h10, 32'h01, 1, 0, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [7:0] a, pv;
      k  = $urandom % 10;
      pv = 8'($urandom) & 8'hEE;
      if ($urandom % 3 != 0) pv = 8'h0;
      case (k)
        0, 1: pulse("R5 rnd pulse", 8'($urandom) & 8'hEE, $urandom, ID_W'($urandom), $urandom % 2);
        2:    xfer("R3 rnd clr", 8'h10, $urandom, 1, 0, pv);
        3:    xfer("R12 rnd mask", 8'h14, $urandom, 1, 0, pv);
        4:    xfer("R6 rnd ctrl", 8'h00, $urandom, 1, 0, pv);
        5:    begin a = 8'($urandom) & 8'h1F; xfer("R7 rnd ofs", a, $urandom, $urandom % 2, 0, pv); end
        6:    xfer("R8 rnd ns", 8'h10, $urandom, $urandom % 2, 1, pv);
        default: begin
          a = (k == 7) ? 8'h10 : ((k == 8) ? 8'h18 : 8'h1C);
          xfer("R9 rnd rd", a, 32'h0, 0, 0, pv);
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule